// File: doc/BRIEF.md
# Debounced Edge-Triggered Input Port Interrupt

This block watches a small group of general-purpose input pins and turns selected transitions on them into interrupt requests. Every pin goes through a two-flop synchronizer. Its level can be read at any time, and it then feeds either a direct path or a debounce filter. The filter accepts a new level only when two consecutive ticks of a selected slow clock see the same value. A per-pin polarity bit chooses the active edge, and a per-pin enable bit gates whether that edge is recorded.

Recorded requests are sticky per-pin flags. Software clears them with a write-one-to-clear strobe, and the flags are ORed into a single interrupt line. Edges are detected on the polarity-adjusted signal, so flipping a pin's polarity bit can raise a request on its own. In sleep, a wake output rises when the synchronized pin levels equal a configured pattern. The prescaler that makes the ticks lives outside the block. The ticks arrive as one-cycle pulses on a tap vector.

Top module: `pin_irq_port`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `level_o`, `flag_o`, `irq_o` and `wake_o` are all zero.
- R2: `level_o[i]` shows `pin_i[i]` after two clock edges, which is the two-flop synchronizer.
- R3: With `deb_en_i[i]`=0 (direct path), an active edge of the synchronized level sets `flag_o[i]` one clock after `level_o[i]` changes.
- R4: `fall_sel_i[i]`=0 makes a rising edge active and `fall_sel_i[i]`=1 makes a falling edge active. The choice is independent for each pin.
- R5: Edges are detected on (selected level XOR `fall_sel_i[i]`) against its value on the previous clock. Changing `fall_sel_i[i]` so that this signal goes from 0 to 1 sets the flag on the next clock.
- R6: A flag is set only by an edge seen while `irq_en_i[i]`=1. An edge seen while the enable was 0 is lost, and setting the enable later does not recover it.
- R7: `flag_o[i]` stays set until a clock on which `clr_i[i]`=1. If an active edge occurs on that same clock, the flag stays set.
- R8: `irq_o` is 1 exactly when any bit of `flag_o` is 1, and it changes on the same clock as the flags.
- R9: With `deb_en_i[i]`=1, the filtered level takes the synchronized value only on a tick where that value equals the sample taken at the previous tick. A pulse shorter than the tick spacing never reaches the edge detector.
- R10: `tick_sel_i` picks tap `tick_i[tick_sel_i]` as the debounce tick. A selector value of `NTAPS` or more gives no tick, so filtered levels hold.
- R11: `wake_o` is 1 on the clock after a cycle in which `sleep_i`=1 and `level_o` equals `wake_pat_i`. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NPINS | Asynchronous pin inputs |
| tick_i | input | NTAPS | One-cycle prescaler tick pulses, one per tap |
| tick_sel_i | input | SELW | Debounce tap select |
| deb_en_i | input | NPINS | Per-pin debounce enable |
| fall_sel_i | input | NPINS | Per-pin polarity, 1 = falling edge |
| irq_en_i | input | NPINS | Per-pin interrupt enable |
| clr_i | input | NPINS | Per-pin write-one-to-clear strobe |
| sleep_i | input | 1 | Sleep mode, arms the wake match |
| wake_pat_i | input | NPINS | Level pattern that wakes the system |
| level_o | output | NPINS | Synchronized pin levels |
| flag_o | output | NPINS | Sticky per-pin request flags |
| irq_o | output | 1 | OR of all request flags |
| wake_o | output | 1 | Wake request |

## Verification
The bench attacks the polarity flip on a quiet pin. A design that detects edges on the raw level and not on the polarity-adjusted one would miss that request. It then enables a pin after its edge has passed, which catches a design that buffers masked edges. It lands a clear and an edge on the same clock, where the wrong priority drops the request. It sends a one-cycle glitch through the debounce path, which a filter needing only one tick sample would pass, and it selects an unused tap, where a design that wraps the index would still debounce. A per-cycle behavioural model also compares every output under random pins, configuration, clears and tap choices.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int unsigned PINS_DEF = 4;
  localparam int unsigned TAPS_DEF = 3;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_pol_e;

  function automatic int unsigned sel_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/pin_debounce.sv
module pin_debounce (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic lvl_i,
  output logic lvl_o
);
  logic last_smp_q;

  // A level is accepted when two successive tick samples agree.
  always_ff @(posedge clk) begin
    if (rst) begin
      last_smp_q <= 1'b0;
      lvl_o      <= 1'b0;
    end else if (tick_i) begin
      last_smp_q <= lvl_i;
      if (lvl_i == last_smp_q) lvl_o <= lvl_i;
    end
  end
endmodule

// File: rtl/pin_edge_flag.sv
module pin_edge_flag
  import pin_irq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  input  logic fall_i,
  input  logic en_i,
  input  logic clr_i,
  output logic flag_nxt_o,
  output logic flag_o
);
  edge_pol_e pol_sel;
  logic      adj;
  logic      adj_q;
  logic      hit;

  assign pol_sel = edge_pol_e'(fall_i);
  assign adj     = lvl_i ^ (pol_sel == EDGE_FALL);
  assign hit     = adj & ~adj_q & en_i;

  // A fresh edge outranks the clear strobe.
  assign flag_nxt_o = hit | (flag_o & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      adj_q  <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      adj_q  <= adj;
      flag_o <= flag_nxt_o;
    end
  end
endmodule

// File: rtl/pin_irq_port.sv
module pin_irq_port
  import pin_irq_pkg::*;
#(
  parameter int unsigned NPINS = PINS_DEF,
  parameter int unsigned NTAPS = TAPS_DEF,
  localparam int unsigned SELW = sel_width(NTAPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NTAPS-1:0] tick_i,
  input  logic [SELW-1:0]  tick_sel_i,
  input  logic [NPINS-1:0] deb_en_i,
  input  logic [NPINS-1:0] fall_sel_i,
  input  logic [NPINS-1:0] irq_en_i,
  input  logic [NPINS-1:0] clr_i,
  input  logic             sleep_i,
  input  logic [NPINS-1:0] wake_pat_i,
  output logic [NPINS-1:0] level_o,
  output logic [NPINS-1:0] flag_o,
  output logic             irq_o,
  output logic             wake_o
);
  logic [NPINS-1:0] sync_lvl;
  logic [NPINS-1:0] deb_lvl;
  logic [NPINS-1:0] flag_nxt;
  logic             tick;

  pin_sync #(.W(NPINS)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pin_i),
    .q_o (sync_lvl)
  );

  // Unused selector codes give no tick at all.
  always_comb begin
    tick = 1'b0;
    for (int t = 0; t < NTAPS; t++) begin
      if (tick_sel_i == SELW'(t)) tick = tick_i[t];
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic path_lvl;

    pin_debounce u_deb (
      .clk    (clk),
      .rst    (rst),
      .tick_i (tick),
      .lvl_i  (sync_lvl[i]),
      .lvl_o  (deb_lvl[i])
    );

    assign path_lvl = deb_en_i[i] ? deb_lvl[i] : sync_lvl[i];

    pin_edge_flag u_edge (
      .clk        (clk),
      .rst        (rst),
      .lvl_i      (path_lvl),
      .fall_i     (fall_sel_i[i]),
      .en_i       (irq_en_i[i]),
      .clr_i      (clr_i[i]),
      .flag_nxt_o (flag_nxt[i]),
      .flag_o     (flag_o[i])
    );
  end

  assign level_o = sync_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o  <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      irq_o  <= |flag_nxt;
      wake_o <= sleep_i & (sync_lvl == wake_pat_i);
    end
  end
endmodule

// File: rtl/pin_irq_port_sva.sv
module pin_irq_port_sva #(
  parameter int unsigned NPINS = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [NPINS-1:0] irq_en_i,
  input logic [NPINS-1:0] clr_i,
  input logic             sleep_i,
  input logic [NPINS-1:0] flag_o,
  input logic             irq_o,
  input logic             wake_o
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (flag_o == '0 && !irq_o && !wake_o));

  p_irq_is_or_r8: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|flag_o));

  p_masked_no_set_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flag_o & ~$past(flag_o) & ~$past(irq_en_i)) == '0));

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(flag_o) & ~$past(clr_i) & ~flag_o) == '0));

  p_wake_needs_sleep_r11: assert property (@(posedge clk) disable iff (rst)
    !sleep_i |=> !wake_o);
endmodule

bind pin_irq_port pin_irq_port_sva #(.NPINS(NPINS)) u_sva (
  .clk      (clk),
  .rst      (rst),
  .irq_en_i (irq_en_i),
  .clr_i    (clr_i),
  .sleep_i  (sleep_i),
  .flag_o   (flag_o),
  .irq_o    (irq_o),
  .wake_o   (wake_o)
);

// File: tb/pin_irq_port_bench.sv
`timescale 1ns/1ps
module pin_irq_port_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] pin_i = '0;
  logic [2:0] tick_i = '0;
  logic [1:0] tick_sel_i = '0;
  logic [3:0] deb_en_i = '0, fall_sel_i = '0, irq_en_i = '0, clr_i = '0;
  logic       sleep_i = 1'b0;
  logic [3:0] wake_pat_i = '0;
  logic [3:0] level_o, flag_o;
  logic       irq_o, wake_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pin_irq_port u_pin_irq_port (
    .clk(clk), .rst(rst), .pin_i(pin_i), .tick_i(tick_i), .tick_sel_i(tick_sel_i),
    .deb_en_i(deb_en_i), .fall_sel_i(fall_sel_i), .irq_en_i(irq_en_i), .clr_i(clr_i),
    .sleep_i(sleep_i), .wake_pat_i(wake_pat_i), .level_o(level_o), .flag_o(flag_o),
    .irq_o(irq_o), .wake_o(wake_o)
  );

  // Tap pulses every 4, 8 and 16 cycles, driven between edges.
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    tick_i[0] = (cyc % 4) == 0;
    tick_i[1] = (cyc % 8) == 3;
    tick_i[2] = (cyc % 16) == 7;
  end

  // Behavioural reference, one update per clock.
  bit m_stage1[4], m_level[4], m_sample[4], m_filt[4], m_seen[4], m_flag[4];
  bit m_irq, m_wake;

  always @(posedge clk) begin
    bit tk, src, adj, any, match;
    bit n_flag[4];
    if (rst) begin
      foreach (m_flag[k]) begin
        m_stage1[k] = 0; m_level[k] = 0; m_sample[k] = 0;
        m_filt[k] = 0; m_seen[k] = 0; m_flag[k] = 0;
      end
      m_irq = 0; m_wake = 0;
    end else begin
      tk = (tick_sel_i < 3) ? tick_i[tick_sel_i] : 1'b0;
      any = 0; match = 1;
      foreach (m_flag[k]) begin
        src = deb_en_i[k] ? m_filt[k] : m_level[k];
        adj = src ^ fall_sel_i[k];
        if (adj && !m_seen[k] && irq_en_i[k]) n_flag[k] = 1;
        else n_flag[k] = m_flag[k] && !clr_i[k];
        m_seen[k] = adj;
        if (m_level[k] != wake_pat_i[k]) match = 0;
        if (tk) begin
          if (m_level[k] == m_sample[k]) m_filt[k] = m_level[k];
          m_sample[k] = m_level[k];
        end
        m_level[k] = m_stage1[k];
        m_stage1[k] = pin_i[k];
        m_flag[k] = n_flag[k];
        any |= n_flag[k];
      end
      m_irq = any;
      m_wake = sleep_i && match;
    end
  end

  function automatic logic [3:0] pack(input bit v[4]);
    logic [3:0] r;
    foreach (v[k]) r[k] = v[k];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n = 1);
    for (int s = 0; s < n; s++) begin
      @(negedge clk);
      chk("R2 level vs model", level_o, pack(m_level));
      chk("R7 flags vs model", flag_o, pack(m_flag));
      chk("R8 irq vs model", irq_o, m_irq);
      chk("R11 wake vs model", wake_o, m_wake);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    chk("R1 flags in reset", flag_o, 4'h0);
    chk("R1 irq in reset", irq_o, 1'b0);
    rst = 1'b0;
    step(1);
    chk("R1 level after reset", level_o, 4'h0);
    chk("R1 wake after reset", wake_o, 1'b0);

    // Direct rising edge on pin 0.
    irq_en_i = 4'hF;
    pin_i = 4'b0001;
    step(2);
    chk("R2 level after two edges", level_o, 4'b0001);
    chk("R3 no flag yet", flag_o, 4'b0000);
    step(1);
    chk("R3 direct edge flag", flag_o, 4'b0001);
    chk("R8 irq follows flag", irq_o, 1'b1);
    clr_i = 4'b0001; step(1); clr_i = '0;
    chk("R7 cleared by strobe", flag_o, 4'b0000);
    chk("R8 irq drops", irq_o, 1'b0);

    // Polarity flip on a low pin fires at once.
    fall_sel_i = 4'b0010;
    step(1);
    chk("R5 polarity flip request", flag_o, 4'b0010);
    clr_i = 4'b0010; step(1); clr_i = '0;
    pin_i = 4'b0011; step(3);
    chk("R4 rising ignored when falling chosen", flag_o[1], 1'b0);
    pin_i = 4'b0001; step(3);
    chk("R4 falling edge flag", flag_o[1], 1'b1);
    clr_i = 4'b0010; step(1); clr_i = '0;

    // Edge while masked is lost.
    irq_en_i = 4'b1011;
    pin_i = 4'b0101; step(4);
    irq_en_i = 4'hF; step(2);
    chk("R6 masked edge not remembered", flag_o[2], 1'b0);

    // Clear and edge on the same clock.
    fall_sel_i[0] = 1'b1; step(1);
    fall_sel_i[0] = 1'b0; step(1);
    chk("R5 flip back sets flag", flag_o[0], 1'b1);
    fall_sel_i[0] = 1'b1; step(1);
    fall_sel_i[0] = 1'b0; clr_i = 4'b0001; step(1);
    chk("R7 edge beats clear", flag_o[0], 1'b1);
    fall_sel_i[0] = 1'b0; step(1);
    clr_i = '0;
    chk("R7 clear alone", flag_o[0], 1'b0);

    // Debounced pin 3, tap 0.
    deb_en_i = 4'b1000; tick_sel_i = 2'd0;
    pin_i = 4'b1101; step(3);
    chk("R9 not yet accepted", flag_o[3], 1'b0);
    step(12);
    chk("R9 accepted after two ticks", flag_o[3], 1'b1);
    clr_i = 4'b1000; step(1); clr_i = '0;
    fall_sel_i[3] = 1'b1; step(1);
    pin_i = 4'b0101; step(1);
    pin_i = 4'b1101; step(20);
    chk("R9 glitch filtered", flag_o[3], 1'b0);
    pin_i = 4'b0101; step(20);
    chk("R9 held low accepted", flag_o[3], 1'b1);
    fall_sel_i[3] = 1'b0; clr_i = 4'b1000; step(1); clr_i = '0;

    // Unused tap code freezes the filter.
    tick_sel_i = 2'd3;
    pin_i = 4'b1101; step(40);
    chk("R10 no tick no accept", flag_o[3], 1'b0);
    chk("R2 level still tracks", level_o, 4'b1101);
    tick_sel_i = 2'd2; step(40);
    chk("R10 slow tap accepts", flag_o[3], 1'b1);

    // Wake matching.
    wake_pat_i = 4'b1101; step(2);
    chk("R11 no wake awake", wake_o, 1'b0);
    sleep_i = 1'b1; step(1);
    chk("R11 wake on match", wake_o, 1'b1);
    wake_pat_i = 4'b0000; step(1);
    chk("R11 no wake on mismatch", wake_o, 1'b0);
    sleep_i = 1'b0;

    // Random traffic against the model.
    for (int r = 0; r < 3000; r++) begin
      pin_i = 4'($urandom);
      if ($urandom_range(0, 15) == 0) begin
        fall_sel_i = 4'($urandom); deb_en_i = 4'($urandom);
        irq_en_i = 4'($urandom); tick_sel_i = 2'($urandom);
      end
      clr_i = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
      sleep_i = $urandom_range(0, 1);
      wake_pat_i = 4'($urandom);
      step(1 + $urandom_range(0, 5));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule